// File: doc/BRIEF.md
# ADC Result Accumulate/Filter Engine

The engine post-processes a stream of converter results, one sequence per trigger. A 3-bit mode selects one of five behaviours: plain conversion (with an optional second conversion), running accumulation, block averaging, burst averaging and a first-order low-pass filter. The engine requests each conversion with a one-cycle pulse. It accepts the matching result on a valid/data input and updates an 18-bit saturating accumulator, an 8-bit saturating sample counter and a 16-bit filtered/averaged value.

On every accepted result the engine forms a signed 17-bit error from a selectable pair of operands: the current result, the stored previous value, the filtered value and a setpoint. When the active mode calls for a threshold test, it compares that error against a signed lower and upper bound. Three sticky flags report a completed sequence, a threshold hit and accumulator saturation. Writing a one to a flag's clear bit clears it. A synchronous clear input resets the arithmetic state.

Top module: `adc_post_engine`

## Requirements
- R1: Modes 0 and 5..7 are plain mode. A trigger requests one conversion, or two back-to-back when dbl_i=1. done_o and the threshold test happen only on the last result of the trigger.
- R2: Mode 1 (accumulate): every result adds to acc_o and increments cnt_o. Every result sets done_o and runs a threshold test.
- R3: Mode 2 (average): every result accumulates and sets done_o. The threshold test runs only when the incremented count reaches rpt_i (0 counts as 1). After such a test, the next trigger clears acc_o and cnt_o before its sample.
- R4: Mode 3 (burst): a trigger clears acc_o and cnt_o. Conversions are then re-requested without further triggers until the count reaches rpt_i. done_o and the test happen once, at the end. A trigger while a sequence runs is ignored.
- R5: Mode 4 (low-pass): filt_o <= filt_o + ((result - filt_o) >>> shift_i). The threshold test starts once the count reaches rpt_i and then runs on every result. done_o is set on every result.
- R6: In modes 1..3, filt_o is acc_o >> shift_i, saturated to 16 bits. In plain mode, filt_o is the raw result.
- R7: calc_i selects the error: 0 res-prev, 1 res-setpoint, 2 filt-setpoint, 3 filt-prev, 4 res-filt, 5 prev-setpoint, 6 filt, 7 res. Here filt is the value after this result's update. prev_o is then loaded with filt (prev_sel_i=1) or with the raw result (0).
- R8: thr_mode_i sets thr_o on a test when the error is: 0 never, 1 < lo, 2 >= lo, 3 < lo or > hi, 4 within [lo,hi], 5 > hi, 6 <= hi, 7 always. All comparisons are signed 17-bit.
- R9: acc_o saturates at 2^18-1 instead of wrapping, and sets ovf_o when it does. cnt_o saturates at 255.
- R10: clr_i resets acc_o, cnt_o, filt_o, prev_o, err_o and any running sequence in the next cycle.
- R11: done_o, thr_o and ovf_o are sticky. They are cleared by flag_clr_i bit 0, 1 and 2 respectively. A set in the same cycle wins over the clear.
- R12: A result presented while no sequence runs is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of arithmetic state |
| flag_clr_i | input | 3 | Write-one clear: bit0 done, bit1 threshold, bit2 overflow |
| mode_i | input | 3 | Operating mode |
| dbl_i | input | 1 | Second conversion per trigger in plain mode |
| rpt_i | input | 8 | Repeat count |
| shift_i | input | 3 | Average / filter shift |
| calc_i | input | 3 | Error operand select |
| prev_sel_i | input | 1 | Previous value source: 0 raw, 1 filtered |
| setpoint_i | input | 16 | Setpoint |
| thr_lo_i | input | 17 | Lower threshold, signed |
| thr_hi_i | input | 17 | Upper threshold, signed |
| thr_mode_i | input | 3 | Threshold comparison |
| trig_i | input | 1 | Start a sequence |
| conv_req_o | output | 1 | Conversion request pulse |
| res_valid_i | input | 1 | Result valid |
| res_i | input | 12 | Conversion result |
| acc_o | output | 18 | Accumulator |
| cnt_o | output | 8 | Sample counter |
| filt_o | output | 16 | Filtered / averaged value |
| prev_o | output | 16 | Stored previous value |
| err_o | output | 17 | Last error, signed |
| done_o | output | 1 | Sticky done flag |
| thr_o | output | 1 | Sticky threshold flag |
| ovf_o | output | 1 | Sticky accumulator saturation flag |

## Verification
Every cycle, the assertions check the following:
- the accumulator never falls outside a clear or trigger, and the counter holds at its ceiling;
- the overflow flag rises only with a full accumulator;
- the flags stay sticky until their clear bit;
- a "never" comparison leaves the threshold flag alone;
- stray results in idle leave the state unchanged;
- a clear empties the state, and requests appear only during a sequence.

The per-mode sequencing needs the bench's scenarios, as do the exact arithmetic of the averaging shift, the filter step and each error selection, and the truth table of every threshold comparison. These cover clear-on-next-trigger in average mode, burst re-requesting, the start of filter testing and double-sample done timing.

// File: rtl/adc_post_pkg.sv
package adc_post_pkg;
  typedef enum logic [2:0] {
    MODE_BASIC = 3'd0,
    MODE_ACCUM = 3'd1,
    MODE_AVG   = 3'd2,
    MODE_BURST = 3'd3,
    MODE_LPF   = 3'd4
  } mode_e;

  typedef enum logic [2:0] {
    CMP_NEVER   = 3'd0,
    CMP_LT_LO   = 3'd1,
    CMP_GE_LO   = 3'd2,
    CMP_OUTSIDE = 3'd3,
    CMP_INSIDE  = 3'd4,
    CMP_GT_HI   = 3'd5,
    CMP_LE_HI   = 3'd6,
    CMP_ALWAYS  = 3'd7
  } cmp_e;

  typedef enum logic [2:0] {
    ERR_RES_PREV  = 3'd0,
    ERR_RES_SP    = 3'd1,
    ERR_FILT_SP   = 3'd2,
    ERR_FILT_PREV = 3'd3,
    ERR_RES_FILT  = 3'd4,
    ERR_PREV_SP   = 3'd5,
    ERR_FILT      = 3'd6,
    ERR_RES       = 3'd7
  } calc_e;
endpackage

// File: rtl/adc_post_seq.sv
module adc_post_seq
  import adc_post_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          trig_i,
  input  logic          res_valid_i,
  input  logic [2:0]    mode_i,
  input  logic          dbl_i,
  input  logic [CW-1:0] rpt_i,
  input  logic [CW-1:0] cnt_i,
  output logic          take_o,
  output logic          acc_clr_o,
  output logic          conv_req_o,
  output logic          done_set_o,
  output logic          test_o,
  output logic          busy_o
);
  logic busy_q, phase_q, full_q, req_q;
  logic start, more, mark;
  logic [CW-1:0] cnt_inc, rpt_eff;
  logic reached;

  assign cnt_inc = (&cnt_i) ? cnt_i : cnt_i + 1'b1;
  assign rpt_eff = (rpt_i == '0) ? CW'(1) : rpt_i;
  assign reached = cnt_inc >= rpt_eff;

  assign start     = !busy_q && trig_i && !clr_i;
  assign take_o    = busy_q && res_valid_i && !clr_i;
  assign acc_clr_o = start && ((mode_i == MODE_BURST) ||
                               ((mode_i == MODE_AVG) && full_q));

  always_comb begin
    more       = 1'b0;
    done_set_o = 1'b0;
    test_o     = 1'b0;
    mark       = 1'b0;
    if (take_o) begin
      case (mode_i)
        MODE_ACCUM: begin
          done_set_o = 1'b1;
          test_o     = 1'b1;
        end
        MODE_AVG: begin
          done_set_o = 1'b1;
          test_o     = reached;
          mark       = reached;
        end
        MODE_BURST: begin
          done_set_o = reached;
          test_o     = reached;
          more       = !reached;
        end
        MODE_LPF: begin
          done_set_o = 1'b1;
          test_o     = reached;
        end
        default: begin
          if (dbl_i && !phase_q) more = 1'b1;
          else begin
            done_set_o = 1'b1;
            test_o     = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      full_q  <= 1'b0;
      req_q   <= 1'b0;
    end else if (clr_i) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      full_q  <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      req_q <= 1'b0;
      if (start) begin
        busy_q  <= 1'b1;
        phase_q <= 1'b0;
        full_q  <= 1'b0;
        req_q   <= 1'b1;
      end else if (take_o) begin
        if (more) begin
          req_q   <= 1'b1;
          phase_q <= 1'b1;
        end else begin
          busy_q <= 1'b0;
        end
        if (mark) full_q <= 1'b1;
      end
    end
  end

  assign conv_req_o = req_q;
  assign busy_o     = busy_q;
endmodule

// File: rtl/adc_post_accum.sv
module adc_post_accum #(
  parameter int DW = 12,
  parameter int AW = 18,
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          acc_clr_i,
  input  logic          take_i,
  input  logic [DW-1:0] res_i,
  output logic [AW-1:0] acc_o,
  output logic [AW-1:0] acc_nxt_o,
  output logic [CW-1:0] cnt_o,
  output logic          ovf_evt_o
);
  logic [AW-1:0] acc_q;
  logic [CW-1:0] cnt_q;
  logic [AW:0]   sum;

  assign sum       = {1'b0, acc_q} + (AW+1)'(res_i);
  assign acc_nxt_o = sum[AW] ? '1 : sum[AW-1:0];
  assign ovf_evt_o = take_i && sum[AW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (clr_i || acc_clr_i) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (take_i) begin
      acc_q <= acc_nxt_o;
      cnt_q <= (&cnt_q) ? cnt_q : cnt_q + 1'b1;
    end
  end

  assign acc_o = acc_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/adc_post_filt.sv
module adc_post_filt
  import adc_post_pkg::*;
#(
  parameter int VW = 16,
  parameter int AW = 18,
  parameter int SW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          take_i,
  input  logic [2:0]    mode_i,
  input  logic [SW-1:0] shift_i,
  input  logic          prev_sel_i,
  input  logic [VW-1:0] res_i,
  input  logic [AW-1:0] acc_nxt_i,
  output logic [VW-1:0] filt_o,
  output logic [VW-1:0] filt_nxt_o,
  output logic [VW-1:0] prev_o
);
  logic [VW-1:0] filt_q, prev_q, avg_v, lpf_v;
  logic [AW-1:0] acc_sh;
  logic signed [VW+1:0] diff, step, lsum;

  assign acc_sh = acc_nxt_i >> shift_i;
  assign avg_v  = (|acc_sh[AW-1:VW]) ? '1 : acc_sh[VW-1:0];

  assign diff  = $signed({2'b00, res_i}) - $signed({2'b00, filt_q});
  assign step  = diff >>> shift_i;
  assign lsum  = $signed({2'b00, filt_q}) + step;
  assign lpf_v = lsum[VW-1:0];

  always_comb begin
    case (mode_i)
      MODE_LPF:                         filt_nxt_o = lpf_v;
      MODE_ACCUM, MODE_AVG, MODE_BURST: filt_nxt_o = avg_v;
      default:                          filt_nxt_o = res_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q <= '0;
      prev_q <= '0;
    end else if (clr_i) begin
      filt_q <= '0;
      prev_q <= '0;
    end else if (take_i) begin
      filt_q <= filt_nxt_o;
      prev_q <= prev_sel_i ? filt_nxt_o : res_i;
    end
  end

  assign filt_o = filt_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/adc_post_thresh.sv
module adc_post_thresh
  import adc_post_pkg::*;
#(
  parameter int VW = 16,
  parameter int EW = 17
) (
  input  logic [2:0]    calc_i,
  input  logic [2:0]    cmp_i,
  input  logic [VW-1:0] res_i,
  input  logic [VW-1:0] prev_i,
  input  logic [VW-1:0] filt_i,
  input  logic [VW-1:0] sp_i,
  input  logic [EW-1:0] lo_i,
  input  logic [EW-1:0] hi_i,
  output logic [EW-1:0] err_o,
  output logic          hit_o
);
  logic [VW-1:0] op_a, op_b;
  logic signed [EW-1:0] err_s, lo_s, hi_s;
  logic below, above;

  always_comb begin
    op_b = '0;
    case (calc_e'(calc_i))
      ERR_RES_PREV:  begin op_a = res_i;  op_b = prev_i; end
      ERR_RES_SP:    begin op_a = res_i;  op_b = sp_i;   end
      ERR_FILT_SP:   begin op_a = filt_i; op_b = sp_i;   end
      ERR_FILT_PREV: begin op_a = filt_i; op_b = prev_i; end
      ERR_RES_FILT:  begin op_a = res_i;  op_b = filt_i; end
      ERR_PREV_SP:   begin op_a = prev_i; op_b = sp_i;   end
      ERR_FILT:      op_a = filt_i;
      default:       op_a = res_i;
    endcase
  end

  assign err_s = $signed(EW'(op_a)) - $signed(EW'(op_b));
  assign lo_s  = $signed(lo_i);
  assign hi_s  = $signed(hi_i);
  assign below = err_s < lo_s;
  assign above = err_s > hi_s;

  always_comb begin
    case (cmp_e'(cmp_i))
      CMP_NEVER:   hit_o = 1'b0;
      CMP_LT_LO:   hit_o = below;
      CMP_GE_LO:   hit_o = !below;
      CMP_OUTSIDE: hit_o = below || above;
      CMP_INSIDE:  hit_o = !below && !above;
      CMP_GT_HI:   hit_o = above;
      CMP_LE_HI:   hit_o = !above;
      default:     hit_o = 1'b1;
    endcase
  end

  assign err_o = err_s;
endmodule

// File: rtl/adc_post_engine.sv
module adc_post_engine #(
  parameter int DW = 12,
  parameter int VW = 16,
  parameter int AW = 18,
  parameter int CW = 8,
  parameter int EW = 17,
  parameter int SW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [2:0]    flag_clr_i,
  input  logic [2:0]    mode_i,
  input  logic          dbl_i,
  input  logic [CW-1:0] rpt_i,
  input  logic [SW-1:0] shift_i,
  input  logic [2:0]    calc_i,
  input  logic          prev_sel_i,
  input  logic [VW-1:0] setpoint_i,
  input  logic [EW-1:0] thr_lo_i,
  input  logic [EW-1:0] thr_hi_i,
  input  logic [2:0]    thr_mode_i,
  input  logic          trig_i,
  output logic          conv_req_o,
  input  logic          res_valid_i,
  input  logic [DW-1:0] res_i,
  output logic [AW-1:0] acc_o,
  output logic [CW-1:0] cnt_o,
  output logic [VW-1:0] filt_o,
  output logic [VW-1:0] prev_o,
  output logic [EW-1:0] err_o,
  output logic          done_o,
  output logic          thr_o,
  output logic          ovf_o
);
  logic          take, acc_clr, done_set, test, busy, ovf_evt, hit;
  logic [AW-1:0] acc_nxt;
  logic [VW-1:0] res_ext, filt_nxt;
  logic [EW-1:0] err_nxt, err_q;
  logic          done_q, thr_q, ovf_q;

  assign res_ext = VW'(res_i);

  adc_post_seq #(.CW(CW)) u_seq (
    .clk_i, .rst_ni, .clr_i, .trig_i, .res_valid_i, .mode_i, .dbl_i, .rpt_i,
    .cnt_i(cnt_o), .take_o(take), .acc_clr_o(acc_clr), .conv_req_o,
    .done_set_o(done_set), .test_o(test), .busy_o(busy)
  );

  adc_post_accum #(.DW(DW), .AW(AW), .CW(CW)) u_accum (
    .clk_i, .rst_ni, .clr_i, .acc_clr_i(acc_clr), .take_i(take), .res_i,
    .acc_o, .acc_nxt_o(acc_nxt), .cnt_o, .ovf_evt_o(ovf_evt)
  );

  adc_post_filt #(.VW(VW), .AW(AW), .SW(SW)) u_filt (
    .clk_i, .rst_ni, .clr_i, .take_i(take), .mode_i, .shift_i, .prev_sel_i,
    .res_i(res_ext), .acc_nxt_i(acc_nxt), .filt_o, .filt_nxt_o(filt_nxt), .prev_o
  );

  adc_post_thresh #(.VW(VW), .EW(EW)) u_thr (
    .calc_i, .cmp_i(thr_mode_i), .res_i(res_ext), .prev_i(prev_o),
    .filt_i(filt_nxt), .sp_i(setpoint_i), .lo_i(thr_lo_i), .hi_i(thr_hi_i),
    .err_o(err_nxt), .hit_o(hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= '0;
    end else if (clr_i) begin
      err_q <= '0;
    end else if (take) begin
      err_q <= err_nxt;
    end
  end

  // set wins over write-one clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      thr_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      done_q <= (done_q && !flag_clr_i[0]) || done_set;
      thr_q  <= (thr_q  && !flag_clr_i[1]) || (test && hit);
      ovf_q  <= (ovf_q  && !flag_clr_i[2]) || ovf_evt;
    end
  end

  assign err_o  = err_q;
  assign done_o = done_q;
  assign thr_o  = thr_q;
  assign ovf_o  = ovf_q;
endmodule

// File: rtl/adc_post_chk.sv
module adc_post_chk #(
  parameter int AW = 18,
  parameter int CW = 8,
  parameter int VW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          clr_i,
  input logic [2:0]    flag_clr_i,
  input logic [2:0]    thr_mode_i,
  input logic          trig_i,
  input logic          res_valid_i,
  input logic          conv_req_o,
  input logic [AW-1:0] acc_o,
  input logic [CW-1:0] cnt_o,
  input logic [VW-1:0] filt_o,
  input logic          done_o,
  input logic          thr_o,
  input logic          ovf_o,
  input logic          busy_i
);
  a_r9_acc_mono: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !trig_i) |=> acc_o >= $past(acc_o));

  a_r9_cnt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cnt_o && !clr_i && !trig_i) |=> &cnt_o);

  a_r9_ovf_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> &acc_o);

  a_r11_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !flag_clr_i[0]) |=> done_o);

  a_r11_thr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_o && !flag_clr_i[1]) |=> thr_o);

  a_r8_never_cmp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!thr_o && thr_mode_i == 3'd0) |=> !thr_o);

  a_r12_idle_res: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && res_valid_i && !trig_i && !clr_i) |=> ($stable(acc_o) && $stable(cnt_o)));

  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (acc_o == '0 && cnt_o == '0 && filt_o == '0));

  a_r4_req_in_seq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o |-> busy_i);
endmodule

bind adc_post_engine adc_post_chk #(.AW(AW), .CW(CW), .VW(VW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .flag_clr_i(flag_clr_i),
  .thr_mode_i(thr_mode_i), .trig_i(trig_i), .res_valid_i(res_valid_i),
  .conv_req_o(conv_req_o), .acc_o(acc_o), .cnt_o(cnt_o), .filt_o(filt_o),
  .done_o(done_o), .thr_o(thr_o), .ovf_o(ovf_o), .busy_i(busy)
);

// File: tb/adc_post_engine_tb_top.sv
module adc_post_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ACC_MAX = 262143;

  logic clk_i = 1'b0, rst_ni = 1'b0, clr_i = 1'b0;
  logic [2:0] flag_clr_i = '0, mode_i = '0, calc_i = '0, thr_mode_i = '0;
  logic dbl_i = 1'b0, prev_sel_i = 1'b0, trig_i = 1'b0, res_valid_i = 1'b0;
  logic [7:0] rpt_i = '0;
  logic [2:0] shift_i = '0;
  logic [15:0] setpoint_i = '0;
  logic [16:0] thr_lo_i = '0, thr_hi_i = '0, err_o;
  logic [11:0] res_i = '0;
  logic conv_req_o, done_o, thr_o, ovf_o;
  logic [17:0] acc_o;
  logic [7:0] cnt_o;
  logic [15:0] filt_o, prev_o;

  adc_post_engine dut_i (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  typedef struct {
    int due; string req;
    int acc, cnt, filt, err;
    bit done, thr, ovf;
  } exp_t;

  exp_t exp_q[$];
  int samp_q[$];
  int cyc = 0, n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit poke_v = 0;
  int poke_d = 0;

  int m_acc, m_cnt, m_filt, m_prev, m_err;
  bit m_done, m_thr, m_ovf, m_busy, m_phase, m_full;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_acc = 0; m_cnt = 0; m_filt = 0; m_prev = 0; m_err = 0;
    m_busy = 0; m_phase = 0; m_full = 0;
  endtask

  task automatic model_trigger();
    if (!m_busy) begin
      m_busy = 1; m_phase = 0;
      if (mode_i == 3 || (mode_i == 2 && m_full)) begin m_acc = 0; m_cnt = 0; end
      m_full = 0;
    end
  endtask

  function automatic bit cmp_hit(input int e);
    int lo, hi;
    lo = int'($signed(thr_lo_i)); hi = int'($signed(thr_hi_i));
    case (thr_mode_i)
      0: return 0;
      1: return e < lo;
      2: return e >= lo;
      3: return e < lo || e > hi;
      4: return e >= lo && e <= hi;
      5: return e > hi;
      6: return e <= hi;
      default: return 1;
    endcase
  endfunction

  task automatic model_sample(input int s);
    int cnt_inc, rpt_eff, sum, acc_n, avg, d, filt_n, sp;
    bit reached, more, done, test, mark, ov;
    exp_t it;
    sp = int'(setpoint_i);
    cnt_inc = (m_cnt == 255) ? 255 : m_cnt + 1;
    rpt_eff = (rpt_i == 0) ? 1 : int'(rpt_i);
    reached = cnt_inc >= rpt_eff;
    sum = m_acc + s;
    ov = sum > ACC_MAX;
    acc_n = ov ? ACC_MAX : sum;
    avg = acc_n >> shift_i;
    if (avg > 65535) avg = 65535;
    d = s - m_filt;
    if (mode_i == 4) filt_n = m_filt + (d >>> shift_i);
    else if (mode_i >= 1 && mode_i <= 3) filt_n = avg;
    else filt_n = s;
    case (calc_i)
      0: m_err = s - m_prev;
      1: m_err = s - sp;
      2: m_err = filt_n - sp;
      3: m_err = filt_n - m_prev;
      4: m_err = s - filt_n;
      5: m_err = m_prev - sp;
      6: m_err = filt_n;
      default: m_err = s;
    endcase
    more = 0; done = 0; test = 0; mark = 0;
    case (mode_i)
      1: begin done = 1; test = 1; end
      2: begin done = 1; test = reached; mark = reached; end
      3: begin done = reached; test = reached; more = !reached; end
      4: begin done = 1; test = reached; end
      default: if (dbl_i && !m_phase) more = 1; else begin done = 1; test = 1; end
    endcase
    if (done) m_done = 1;
    if (test && cmp_hit(m_err)) m_thr = 1;
    if (ov) m_ovf = 1;
    if (mark) m_full = 1;
    if (more) m_phase = 1; else m_busy = 0;
    m_prev = prev_sel_i ? filt_n : s;
    m_acc = acc_n; m_cnt = cnt_inc; m_filt = filt_n;
    it.due = cyc + 1; it.req = cur_req;
    it.acc = m_acc; it.cnt = m_cnt; it.filt = m_filt; it.err = m_err;
    it.done = m_done; it.thr = m_thr; it.ovf = m_ovf;
    exp_q.push_back(it);
  endtask

  // converter model / driver
  initial begin
    forever begin
      @(negedge clk_i);
      res_valid_i = poke_v;
      res_i = 12'(poke_d);
      if (rst_ni && conv_req_o) begin
        if (samp_q.size() == 0) chk(cur_req, "unexpected conv_req", 1, 0);
        else begin
          res_i = 12'(samp_q[0]);
          res_valid_i = 1'b1;
          model_sample(samp_q.pop_front());
        end
      end
    end
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk_i);
      if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.req, "acc", acc_o, e.acc);
        chk(e.req, "cnt", cnt_o, e.cnt);
        chk(e.req, "filt", filt_o, e.filt);
        chk(e.req, "err", int'($signed(err_o)), e.err);
        chk(e.req, "done", done_o, e.done);
        chk(e.req, "thr", thr_o, e.thr);
        chk(e.req, "ovf", ovf_o, e.ovf);
      end
    end
  end

  initial forever begin @(posedge clk_i); cyc++; end

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  task automatic run_trig(input bit mid_trig = 0);
    @(negedge clk_i); model_trigger(); trig_i = 1'b1;
    @(negedge clk_i); trig_i = 1'b0;
    if (mid_trig) begin
      @(negedge clk_i); model_trigger(); trig_i = 1'b1;
      @(negedge clk_i); trig_i = 1'b0;
    end
    while (m_busy || exp_q.size() > 0) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic go1(input int s);
    samp_q.push_back(s); run_trig();
  endtask

  task automatic do_clr();
    @(negedge clk_i); clr_i = 1'b1; model_reset();
    @(negedge clk_i); clr_i = 1'b0;
  endtask

  task automatic clr_flags();
    @(negedge clk_i); flag_clr_i = 3'b111; m_done = 0; m_thr = 0; m_ovf = 0;
    @(negedge clk_i); flag_clr_i = 3'b000;
  endtask

  initial begin
    model_reset(); m_done = 0; m_thr = 0; m_ovf = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    cur_req = "R10";
    chk("R10", "reset acc", acc_o, 0);
    chk("R10", "reset cnt", cnt_o, 0);
    chk("R10", "reset filt", filt_o, 0);
    chk("R11", "reset flags", {done_o, thr_o, ovf_o}, 0);
    chk("R1", "reset req", conv_req_o, 0);

    // R1 plain single
    cur_req = "R1"; mode_i = 0; calc_i = 7; thr_mode_i = 5; thr_hi_i = 100; thr_lo_i = 0;
    go1(200);
    chk("R1", "single done", done_o, 1);
    chk("R8", "gt_hi hit", thr_o, 1);
    clr_flags();
    chk("R11", "flags cleared", {done_o, thr_o}, 0);

    // R1 plain double: done only after second
    dbl_i = 1; calc_i = 0; thr_mode_i = 0;
    samp_q.push_back(10); samp_q.push_back(30); run_trig();
    chk("R1", "double err res-prev", int'($signed(err_o)), 20);
    dbl_i = 0;

    // R2 accumulate
    do_clr();
    chk("R10", "clr acc", acc_o, 0);
    cur_req = "R2"; mode_i = 1; shift_i = 1; calc_i = 6; thr_mode_i = 7;
    go1(100); go1(200); go1(300);
    chk("R2", "acc sum", acc_o, 600);
    chk("R6", "acc>>1", filt_o, 300);
    clr_flags();

    // R3 average
    do_clr();
    cur_req = "R3"; mode_i = 2; rpt_i = 4; shift_i = 2; calc_i = 6; thr_mode_i = 7;
    go1(40); go1(80); go1(120);
    chk("R3", "no test before rpt", thr_o, 0);
    go1(160);
    chk("R3", "test at rpt", thr_o, 1);
    chk("R6", "average value", filt_o, 100);
    clr_flags();
    go1(8);
    chk("R3", "acc cleared on next trig", acc_o, 8);
    chk("R3", "no test after restart", thr_o, 0);

    // R4 burst with ignored mid-sequence trigger
    clr_flags();
    cur_req = "R4"; mode_i = 3; rpt_i = 3; shift_i = 0; thr_mode_i = 7;
    samp_q.push_back(1000); samp_q.push_back(2000); samp_q.push_back(3000);
    run_trig(1);
    chk("R4", "burst acc", acc_o, 6000);
    chk("R4", "burst cnt", cnt_o, 3);
    chk("R12", "no leftover request", samp_q.size(), 0);

    // R5 low-pass
    do_clr(); clr_flags();
    cur_req = "R5"; mode_i = 4; rpt_i = 2; shift_i = 2; calc_i = 2; setpoint_i = 300;
    thr_mode_i = 5; thr_hi_i = 0;
    go1(1000);
    chk("R5", "no test first sample", thr_o, 0);
    go1(1000); go1(1000);
    chk("R5", "filter value", filt_o, 577);
    chk("R5", "test after rpt", thr_o, 1);
    clr_flags();
    prev_sel_i = 1; calc_i = 0;
    go1(1000);
    chk("R7", "prev holds filtered", prev_o, m_filt);
    prev_sel_i = 0;

    // R7 error selects
    cur_req = "R7"; mode_i = 0; setpoint_i = 500; thr_mode_i = 0;
    for (int c = 0; c < 8; c++) begin
      calc_i = 3'(c);
      go1(300 + c * 10);
    end

    // R8 threshold comparisons
    cur_req = "R8"; calc_i = 7; thr_lo_i = 100; thr_hi_i = 200;
    for (int m = 0; m < 8; m++) begin
      for (int v = 0; v < 3; v++) begin
        clr_flags();
        thr_mode_i = 3'(m);
        go1(50 + v * 100);
      end
    end
    // signed bound: error negative against negative lower bound
    clr_flags();
    calc_i = 1; setpoint_i = 1000; thr_lo_i = -17'sd100; thr_mode_i = 1;
    go1(800);
    chk("R8", "signed lt_lo", thr_o, 1);

    // R12 result while idle
    cur_req = "R12";
    @(posedge clk_i); poke_v = 1; poke_d = 77;
    @(posedge clk_i); poke_v = 0;
    @(negedge clk_i); @(negedge clk_i);
    chk("R12", "idle result acc", acc_o, m_acc);
    chk("R12", "idle result cnt", cnt_o, m_cnt);

    // R9 saturation
    do_clr(); clr_flags();
    cur_req = "R9"; mode_i = 1; shift_i = 0; thr_mode_i = 0;
    for (int i = 0; i < 260; i++) go1(4095);
    chk("R9", "acc saturated", acc_o, ACC_MAX);
    chk("R9", "cnt saturated", cnt_o, 255);
    chk("R9", "ovf flag", ovf_o, 1);
    chk("R6", "avg saturated", filt_o, 65535);
    clr_flags();
    chk("R11", "ovf cleared", ovf_o, 0);

    repeat (3) @(negedge clk_i);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule